// File: doc/BRIEF.md
# SPI Master Register and Interrupt Front End

This block is the host-facing half of an SPI master. A simple register port carries 32-bit reads and writes at fixed word offsets. The block holds the configuration and enable state, two byte queues between the host and the serial shift engine, and a seven-source interrupt unit that drives one interrupt line.

Software sets the clock mode, divisor and slave selects through the control word, turns the controller on, and queues outgoing bytes by writing the transmit data word. The shift engine takes bytes from the transmit queue and returns received bytes into the receive queue. Software drains that queue by reading the receive data word.

Interrupt status mixes two kinds of bit. Live queue-level flags always follow the queues. Sticky error events stay set until software writes a one to clear them. The mask is changed only through a set register and a clear register.

Top module: `spi_fe_top`

## Requirements
- R1: Word offsets (byte address bits [5:2]) decode as: 0x00 control, 0x04 status, 0x08 mask-set, 0x0C mask-clear, 0x10 mask, 0x14 enable, 0x18 delay, 0x1C transmit data, 0x20 receive data. Control keeps only bits 15, 14, 13:10, 5:3, 2, 1 and 0, so its read mask is 0x0000FC3F. Delay reads back all 32 bits. Any other offset, and both mask-set and mask-clear, read as zero.
- R2: The configuration outputs follow the control word: cfg_man_start bit 15, cfg_man_cs bit 14, cfg_sel bits 13:10, cfg_baud bits 5:3, cfg_cpha bit 2, cfg_cpol bit 1, cfg_master bit 0. eng_en follows bit 0 of the enable word, which reads back as that one bit.
- R3: A write to the transmit data word while enabled pushes bits 7:0 onto a 128-entry transmit queue. The engine sees the bytes in order on tx_byte while tx_avail is high and removes one per tx_take. A push to a full queue is dropped.
- R4: A read of the receive data word returns the oldest received byte in bits 7:0 and removes it. A read of an empty queue returns zero. rx_put while enabled appends rx_byte to the 128-entry receive queue.
- R5: Status level bits follow the queues and ignore clear writes: bit 1 transmit empty, bit 2 transmit not full, bit 3 transmit full, bit 4 receive not empty, bit 5 receive full.
- R6: Status bit 0 is a sticky receive overflow, set by rx_put to a full queue (the byte is dropped). Status bit 6 is a sticky transmit underflow, set by tx_take while the transmit queue is empty and the controller is enabled. Writing a one to the bit's position in the status word clears it.
- R7: Writing ones to mask-set adds those sources to the mask. Writing ones to mask-clear removes them. The mask word is read-only, so writes to it are ignored.
- R8: irq is high exactly when some status bit is set and its mask bit is set.
- R9: When the controller is off, or in the cycle it is turned off, both queues are emptied. While off, pushes to either queue are ignored, tx_take raises no underflow, and eng_en is low.
- R10: After reset, control, enable, delay, mask and the event bits are zero, so status reads 0x06 and irq is low.
- R11: A read request is answered in the next cycle with rsp_valid high for one cycle. rsp_valid stays low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 6 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| tx_avail | output | 1 | Transmit queue holds a byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_take | input | 1 | Engine removes the transmit head |
| rx_put | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| irq | output | 1 | Interrupt request |
| eng_en | output | 1 | Controller enabled |
| cfg_master | output | 1 | Master mode select |
| cfg_cpol | output | 1 | Clock polarity |
| cfg_cpha | output | 1 | Clock phase |
| cfg_baud | output | 3 | Baud divisor code |
| cfg_sel | output | 4 | Slave select lines |
| cfg_man_cs | output | 1 | Manual chip select |
| cfg_man_start | output | 1 | Manual start enable |
| cfg_delay | output | 32 | Delay word |

## Verification
A seeded random mix of transmit writes, engine takes, engine deliveries, receive reads, mask changes and status clears runs against a queue model. It shows whether byte order and level flags stay right while both queues fill and drain together. Directed runs fill each queue past 128 entries, which separates dropped pushes from lost bytes and shows when the sticky errors set. Clear writes to level bits show that only event bits respond. Writes to the read-only mask, control bits outside the kept set, and a disable with data in flight each show a path that must leave state untouched or must flush.

// File: rtl/spi_fe_pkg.sv
// Shared constants of the SPI front end: word offsets and status bit layout.
package spi_fe_pkg;
    localparam int unsigned OFS_CTRL  = 0;
    localparam int unsigned OFS_STAT  = 1;
    localparam int unsigned OFS_MSET  = 2;
    localparam int unsigned OFS_MCLR  = 3;
    localparam int unsigned OFS_MASK  = 4;
    localparam int unsigned OFS_ENA   = 5;
    localparam int unsigned OFS_DLY   = 6;
    localparam int unsigned OFS_TXD   = 7;
    localparam int unsigned OFS_RXD   = 8;

    localparam int IRQ_N = 7;
    localparam int B_RX_OVF   = 0;
    localparam int B_TX_EMPTY = 1;
    localparam int B_TX_NFULL = 2;
    localparam int B_TX_FULL  = 3;
    localparam int B_RX_NEMP  = 4;
    localparam int B_RX_FULL  = 5;
    localparam int B_TX_UDF   = 6;

    localparam logic [IRQ_N-1:0] EVT_BITS  = 7'b100_0001;
    localparam logic [31:0]      CTRL_KEEP = 32'h0000_FC3F;
endpackage

// File: rtl/spi_fe_fifo.sv
// Byte queue with flush. Assumes DEPTH is a power of two.
// A push to a full queue and a pop from an empty queue are ignored.
module spi_fe_fifo #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Pointer and occupancy update; reset and flush both empty the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/spi_fe_irq.sv
// Interrupt status, mask and request line. Bits listed in EVT are sticky
// events (set by ev_set, cleared by write-one); the others pass the live
// level input through. The mask changes only by set and clear strobes.
module spi_fe_irq #(
    parameter int          N   = 7,
    parameter logic [N-1:0] EVT = 7'b100_0001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    input  logic [N-1:0] ev_set,
    input  logic         clr_wr,
    input  logic         set_wr,
    input  logic         dis_wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status,
    output logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] ev_q;

    // Per-bit choice between sticky event and live level.
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (EVT[i]) begin : g_evt
            // Sticky event: a new event wins over a same-cycle clear.
            always_ff @(posedge clk) begin
                if (!rst_n)                   ev_q[i] <= 1'b0;
                else if (ev_set[i])           ev_q[i] <= 1'b1;
                else if (clr_wr && wdata[i])  ev_q[i] <= 1'b0;
            end
            assign status[i] = ev_q[i];
        end else begin : g_lvl
            assign ev_q[i]   = 1'b0;
            assign status[i] = level[i];
        end
    end

    // Mask update from the set and clear registers.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask <= '0;
        else if (set_wr) mask <= mask | wdata;
        else if (dis_wr) mask <= mask & ~wdata;
    end

    assign irq = |(status & mask);
endmodule

// File: rtl/spi_fe_top.sv
// Register front end of an SPI master: decodes the register port, holds
// control, enable and delay words, owns both byte queues and the interrupt
// unit. Assumes at most one request per cycle; reads answer one cycle later.
module spi_fe_top
    import spi_fe_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int ADDR_W     = 6,
    localparam int WORD_W    = ADDR_W - 2,
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              tx_avail,
    output logic [7:0]        tx_byte,
    input  logic              tx_take,
    input  logic              rx_put,
    input  logic [7:0]        rx_byte,
    output logic              irq,
    output logic              eng_en,
    output logic              cfg_master,
    output logic              cfg_cpol,
    output logic              cfg_cpha,
    output logic [2:0]        cfg_baud,
    output logic [3:0]        cfg_sel,
    output logic              cfg_man_cs,
    output logic              cfg_man_start,
    output logic [31:0]       cfg_delay
);
    logic [WORD_W-1:0] word;
    logic              wr, rd;
    logic [31:0]       ctrl_q;
    logic              en_q, flush;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic [7:0]        rx_head;
    logic [IRQ_N-1:0]  level, ev_set, stat_w, mask_q;

    assign word = req_addr[ADDR_W-1:2];
    assign wr   = req_valid && req_write;
    assign rd   = req_valid && !req_write;

    // Control, enable and delay words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            en_q      <= 1'b0;
            cfg_delay <= '0;
        end else if (wr) begin
            if (word == WORD_W'(OFS_CTRL)) ctrl_q    <= req_wdata & CTRL_KEEP;
            if (word == WORD_W'(OFS_ENA))  en_q      <= req_wdata[0];
            if (word == WORD_W'(OFS_DLY))  cfg_delay <= req_wdata;
        end
    end

    // Queues empty while off and at the edge that turns the block off.
    assign flush = (wr && word == WORD_W'(OFS_ENA)) ? !req_wdata[0] : !en_q;

    spi_fe_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(wr && en_q && word == WORD_W'(OFS_TXD)), .din(req_wdata[7:0]),
        .pop(tx_take), .dout(tx_byte),
        .empty(tx_empty), .full(tx_full), .count(tx_cnt)
    );

    spi_fe_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rx_put && en_q), .din(rx_byte),
        .pop(rd && word == WORD_W'(OFS_RXD)), .dout(rx_head),
        .empty(rx_empty), .full(rx_full), .count(rx_cnt)
    );

    // Live level flags and error events feeding the interrupt unit.
    always_comb begin
        level             = '0;
        level[B_TX_EMPTY] = tx_empty;
        level[B_TX_NFULL] = !tx_full;
        level[B_TX_FULL]  = tx_full;
        level[B_RX_NEMP]  = !rx_empty;
        level[B_RX_FULL]  = rx_full;
        ev_set            = '0;
        ev_set[B_RX_OVF]  = rx_put && en_q && rx_full;
        ev_set[B_TX_UDF]  = tx_take && en_q && tx_empty;
    end

    spi_fe_irq #(.N(IRQ_N), .EVT(EVT_BITS)) u_irq (
        .clk(clk), .rst_n(rst_n), .level(level), .ev_set(ev_set),
        .clr_wr(wr && word == WORD_W'(OFS_STAT)),
        .set_wr(wr && word == WORD_W'(OFS_MSET)),
        .dis_wr(wr && word == WORD_W'(OFS_MCLR)),
        .wdata(req_wdata[IRQ_N-1:0]),
        .status(stat_w), .mask(mask_q), .irq(irq)
    );

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd;
            if (rd) begin
                case (word)
                    WORD_W'(OFS_CTRL): rsp_rdata <= ctrl_q;
                    WORD_W'(OFS_STAT): rsp_rdata <= 32'(stat_w);
                    WORD_W'(OFS_MASK): rsp_rdata <= 32'(mask_q);
                    WORD_W'(OFS_ENA):  rsp_rdata <= 32'(en_q);
                    WORD_W'(OFS_DLY):  rsp_rdata <= cfg_delay;
                    WORD_W'(OFS_RXD):  rsp_rdata <= rx_empty ? 32'd0 : 32'(rx_head);
                    default:           rsp_rdata <= '0;
                endcase
            end
        end
    end

    assign tx_avail      = !tx_empty;
    assign eng_en        = en_q;
    assign cfg_master    = ctrl_q[0];
    assign cfg_cpol      = ctrl_q[1];
    assign cfg_cpha      = ctrl_q[2];
    assign cfg_baud      = ctrl_q[5:3];
    assign cfg_sel       = ctrl_q[13:10];
    assign cfg_man_cs    = ctrl_q[14];
    assign cfg_man_start = ctrl_q[15];
endmodule

// File: rtl/spi_fe_checker.sv
// Protocol and state properties of the SPI front end, bound to the top.
module spi_fe_checker #(
    parameter int ADDR_W     = 6,
    parameter int FIFO_DEPTH = 128,
    parameter int CNT_W      = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic              irq,
    input logic              eng_en,
    input logic              tx_avail,
    input logic              tx_take,
    input logic [6:0]        stat_w,
    input logic [6:0]        mask_q,
    input logic [CNT_W-1:0]  tx_cnt
);
    logic [ADDR_W-3:0] w;
    assign w = req_addr[ADDR_W-1:2];

    a_r11_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> rsp_valid);
    a_r11_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);
    a_r7_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && w == 2 |=>
        ((mask_q & $past(req_wdata[6:0])) == $past(req_wdata[6:0])));
    a_r7_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && w == 3 |=>
        ((mask_q & $past(req_wdata[6:0])) == 7'd0));
    a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q == 7'd0 |-> !irq);
    a_r9_off_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_en |-> !tx_avail);
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stat_w[0] && !(req_valid && req_write && w == 1 && req_wdata[0]) |=> stat_w[0]);
    a_r5_tx_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_w[1], stat_w[3]}) && (stat_w[2] != stat_w[3]));
    a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt == CNT_W'(FIFO_DEPTH) && !tx_take && !(req_valid && req_write && w == 5)
        |=> tx_cnt == CNT_W'(FIFO_DEPTH));
endmodule

bind spi_fe_top spi_fe_checker #(
    .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .irq(irq), .eng_en(eng_en), .tx_avail(tx_avail), .tx_take(tx_take),
    .stat_w(stat_w), .mask_q(mask_q), .tx_cnt(tx_cnt)
);

// File: tb/spi_fe_top_test.sv
// Self-checking bench: seeded random traffic against a queue model plus
// directed corner cases.
module spi_fe_top_test;
    localparam int CLK_P = 10;
    localparam int DEPTH = 128;

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_write = 0;
    logic [5:0]  req_addr = 0;
    logic [31:0] req_wdata = 0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        tx_avail, tx_take = 0, rx_put = 0;
    logic [7:0]  tx_byte, rx_byte = 0;
    logic        irq, eng_en, cfg_master, cfg_cpol, cfg_cpha, cfg_man_cs, cfg_man_start;
    logic [2:0]  cfg_baud;
    logic [3:0]  cfg_sel;
    logic [31:0] cfg_delay;

    int checks = 0, errors = 0;
    logic [7:0] txq[$], rxq[$];
    logic [6:0] m_mask = 0;
    logic       m_ovf = 0, m_udf = 0, m_en = 0;

    spi_fe_top uut (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat();
        logic [31:0] s = 0;
        s[0] = m_ovf; s[6] = m_udf;
        s[1] = txq.size() == 0;
        s[2] = txq.size() < DEPTH;
        s[3] = txq.size() == DEPTH;
        s[4] = rxq.size() != 0;
        s[5] = rxq.size() == DEPTH;
        return s;
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        case (a)
            6'h04: begin if (d[0]) m_ovf = 0; if (d[6]) m_udf = 0; end
            6'h08: m_mask = m_mask | d[6:0];
            6'h0C: m_mask = m_mask & ~d[6:0];
            6'h14: begin m_en = d[0]; if (!d[0]) begin txq.delete(); rxq.delete(); end end
            6'h1C: if (m_en && txq.size() < DEPTH) txq.push_back(d[7:0]);
            default: ;
        endcase
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        chk(rsp_valid === 1'b1, "R11 rsp_valid", 32'(rsp_valid), 1);
        d = rsp_rdata;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R11 single-cycle rsp", 32'(rsp_valid), 0);
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] e, input string req);
        logic [31:0] d;
        rd(a, d);
        chk(d === e, req, d, e);
    endtask

    task automatic take();
        if (m_en && txq.size() != 0) begin
            logic [7:0] e = txq.pop_front();
            chk(tx_avail === 1'b1 && tx_byte === e, "R3 tx byte order", {23'b0, tx_avail, tx_byte}, {24'h1, e});
        end else begin
            chk(tx_avail === 1'b0, "R3 tx_avail low when empty", 32'(tx_avail), 0);
            if (m_en) m_udf = 1;
        end
        tx_take = 1;
        @(negedge clk);
        tx_take = 0;
    endtask

    task automatic put(input logic [7:0] b);
        rx_put = 1; rx_byte = b;
        @(negedge clk);
        rx_put = 0;
        if (m_en) begin
            if (rxq.size() < DEPTH) rxq.push_back(b);
            else m_ovf = 1;
        end
    endtask

    task automatic pop_rx(input string req);
        logic [31:0] e = (rxq.size() != 0) ? 32'(rxq.pop_front()) : 32'd0;
        rd_chk(6'h20, e, req);
    endtask

    task automatic chk_stat_irq(input string req);
        chk(irq === |(exp_stat() & 32'(m_mask)), "R8 irq", 32'(irq), 32'(|(exp_stat() & 32'(m_mask))));
        rd_chk(6'h04, exp_stat(), req);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL R11 watchdog actual=hang expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2741));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10 reset state
        chk(irq === 0 && eng_en === 0 && tx_avail === 0, "R10 outputs after reset",
            {29'b0, irq, eng_en, tx_avail}, 0);
        rd_chk(6'h04, 32'h06, "R10 status after reset");
        rd_chk(6'h10, 0, "R10 mask after reset");
        rd_chk(6'h00, 0, "R10 control after reset");

        // R1 R2 control and decode
        wr(6'h00, 32'hFFFF_FFFF);
        rd_chk(6'h00, 32'h0000_FC3F, "R1 control keep mask");
        wr(6'h00, 32'h0000_9C2A);
        chk({cfg_man_start, cfg_man_cs, cfg_sel, cfg_baud, cfg_cpha, cfg_cpol, cfg_master} === 12'b1_0_0111_101_0_1_0,
            "R2 cfg fields", {20'b0, cfg_man_start, cfg_man_cs, cfg_sel, cfg_baud, cfg_cpha, cfg_cpol, cfg_master},
            32'b1_0_0111_101_0_1_0);
        wr(6'h18, 32'hDEAD_BEEF);
        rd_chk(6'h18, 32'hDEAD_BEEF, "R1 delay readback");
        chk(cfg_delay === 32'hDEAD_BEEF, "R1 cfg_delay", cfg_delay, 32'hDEAD_BEEF);
        rd_chk(6'h24, 0, "R1 unmapped reads zero");
        rd_chk(6'h08, 0, "R1 mask-set reads zero");

        // R9 pushes ignored while off
        wr(6'h1C, 32'h55);
        put(8'h66);
        take();
        chk_stat_irq("R9 off ignores pushes and takes");

        wr(6'h14, 32'hFFFF_FFFF);
        chk(eng_en === 1, "R2 eng_en on", 32'(eng_en), 1);
        rd_chk(6'h14, 1, "R2 enable reads one bit");

        // R7 mask register writes ignored; R8 irq via set/clear
        wr(6'h10, 32'h7F);
        rd_chk(6'h10, 0, "R7 mask read-only");
        wr(6'h08, 32'h02);
        chk(irq === 1, "R8 irq on tx empty", 32'(irq), 1);
        wr(6'h0C, 32'h02);
        chk(irq === 0, "R8 irq masked off", 32'(irq), 0);

        // R3 fill past depth, drop extra
        for (int i = 0; i < DEPTH + 2; i++) wr(6'h1C, 32'hAB00 + i);
        chk_stat_irq("R5 tx full flags");
        wr(6'h04, 32'h7F);
        chk_stat_irq("R5 level bits ignore clear");
        for (int i = 0; i < DEPTH; i++) take();
        take();
        chk_stat_irq("R6 tx underflow set");

        // R4 R6 receive overflow
        for (int i = 0; i < DEPTH + 1; i++) put(8'(i * 3 + 1));
        wr(6'h08, 32'h01);
        chk_stat_irq("R6 rx overflow set");
        wr(6'h04, 32'h01);
        chk_stat_irq("R6 overflow cleared, underflow kept");
        for (int i = 0; i < 4; i++) pop_rx("R4 rx order");

        // R9 disable with data in flight
        wr(6'h1C, 32'h11);
        wr(6'h14, 0);
        chk(tx_avail === 0 && eng_en === 0, "R9 flush on disable", {30'b0, tx_avail, eng_en}, 0);
        chk_stat_irq("R9 status after flush");
        wr(6'h14, 1);
        pop_rx("R4 empty read returns zero");

        // Random mix
        for (int i = 0; i < 1500; i++) begin
            case ($urandom % 9)
                0, 1: wr(6'h1C, $urandom);
                2:    take();
                3, 4: put(8'($urandom));
                5:    pop_rx("R4 random rx data");
                6:    chk_stat_irq("R5 R6 random status");
                7:    wr(($urandom % 2) ? 6'h08 : 6'h0C, $urandom);
                8:    if ($urandom % 8 == 0) wr(6'h14, $urandom % 4 != 0);
                      else wr(6'h04, $urandom);
                default: ;
            endcase
        end
        chk_stat_irq("R5 final status");
        rd_chk(6'h10, 32'(m_mask), "R7 final mask");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule